// File: doc/BRIEF.md
# Masked Interrupt Event Aggregator

This block keeps the interrupt state of a network DMA controller. It holds a 32-bit event register and a 32-bit mask register. Hardware sources raise event bits with one-cycle pulses. Two side inputs raise the completion events of the graceful receive stop and the graceful transmit stop. Software clears event bits by writing ones, and it loads the mask with a plain write.

The bits that are both pending and enabled form the active set. Three constant group masks divide the active set into transmit, receive and error groups. Each group drives one level-sensitive interrupt line, which is high whenever any active bit of its group is set. Bits outside all three groups never raise a line.

The lines are combinational functions of the two registers. They therefore follow every register change in the same cycle that the new register value appears, whether software or hardware made the change. The register bus has no valid/ready handshake: a write takes effect at the clock edge where `wr_en` is high, and a read returns data combinationally.

Top module: `irq_event_agg`

## Requirements
- R1: After reset the event register holds `EVT_RST` and the mask holds `MSK_RST` (both 0 by default). The three lines are evaluated from those values at once, so all are low by default.
- R2: A write to address 0 clears every event bit whose write-data bit is 1 and leaves the other event bits unchanged. The cleared value is visible one clock edge after the write.
- R3: A write to address 1 replaces the whole mask with the write data.
- R4: A high bit on `hw_set` sets the matching event bit at that clock edge.
- R5: If a hardware set and a software clear hit the same event bit in one cycle, the bit ends up set.
- R6: Each line is the OR of its group in the active set, where active = event AND mask. Line `irq_tx` uses `TX_GROUP` (default bits 7:0), `irq_rx` uses `RX_GROUP` (default bits 15:8) and `irq_err` uses `ERR_GROUP` (default bits 23:16). Each line changes in the same cycle as the register value it depends on.
- R7: Active bits that lie outside all three groups (default bits 31:24) never assert any line.
- R8: A pulse on `rx_stop_done` sets event bit `RX_STOP_BIT` (default 9). A pulse on `tx_stop_done` sets event bit `TX_STOP_BIT` (default 1).
- R9: A read of address 0 returns the event register and a read of address 1 returns the mask. Reads of any other address return 0, and writes to any other address change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 = event, 1 = mask) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| hw_set | input | DATA_W | Per-bit event set pulses |
| rx_stop_done | input | 1 | Graceful receive stop completed |
| tx_stop_done | input | 1 | Graceful transmit stop completed |
| irq_tx | output | 1 | Transmit interrupt level |
| irq_rx | output | 1 | Receive interrupt level |
| irq_err | output | 1 | Error interrupt level |

## Verification
A wrong event bit shows at `rd_data` one edge after the set or clear that caused it. If that bit is enabled and grouped, it also shows on its line in the same cycle. A wrong mask bit is hidden from the lines until a matching event is pending, so the stimulus first loads all-ones masks under pending events and then narrows them. A lost set-over-clear priority or a leaking ungrouped bit shows as a wrong line level in the cycle right after the colliding or ungrouped event.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NUM_LINES = 3;
  typedef enum int unsigned {
    LINE_TX  = 0,
    LINE_RX  = 1,
    LINE_ERR = 2
  } irq_line_e;
endpackage

// File: rtl/irq_evt_reg.sv
module irq_evt_reg #(
  parameter int unsigned W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] set_bits,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q[i] <= RST[i];
      else if (set_bits[i])              q[i] <= 1'b1;  // set has priority
      else if (clr_en && clr_bits[i])    q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_msk_reg.sv
module irq_msk_reg #(
  parameter int unsigned W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST;
    else if (ld_en) q <= ld_data;
  end
endmodule

// File: rtl/irq_grp_reduce.sv
module irq_grp_reduce #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 3,
  parameter logic [N-1:0][W-1:0] GROUPS = '0
) (
  input  logic [W-1:0] evt,
  input  logic [W-1:0] msk,
  output logic [N-1:0] lines
);
  logic [W-1:0] active;
  assign active = evt & msk;
  for (genvar g = 0; g < N; g++) begin : g_line
    assign lines[g] = |(active & GROUPS[g]);
  end
endmodule

// File: rtl/irq_event_agg.sv
module irq_event_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 2,
  parameter logic [DATA_W-1:0] EVT_RST   = '0,
  parameter logic [DATA_W-1:0] MSK_RST   = '0,
  parameter logic [DATA_W-1:0] TX_GROUP  = 32'h0000_00FF,
  parameter logic [DATA_W-1:0] RX_GROUP  = 32'h0000_FF00,
  parameter logic [DATA_W-1:0] ERR_GROUP = 32'h00FF_0000,
  parameter int unsigned RX_STOP_BIT  = 9,
  parameter int unsigned TX_STOP_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] hw_set,
  input  logic              rx_stop_done,
  input  logic              tx_stop_done,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err
);
  localparam logic [ADDR_W-1:0] EVT_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] MSK_ADDR = ADDR_W'(1);
  localparam logic [NUM_LINES-1:0][DATA_W-1:0] GROUPS = {ERR_GROUP, RX_GROUP, TX_GROUP};

  logic [DATA_W-1:0]    evt_q, msk_q, set_all;
  logic [NUM_LINES-1:0] lines;
  logic                 evt_wr, msk_wr;

  assign evt_wr  = wr_en && (wr_addr == EVT_ADDR);
  assign msk_wr  = wr_en && (wr_addr == MSK_ADDR);
  assign set_all = hw_set
                 | (DATA_W'(rx_stop_done) << RX_STOP_BIT)
                 | (DATA_W'(tx_stop_done) << TX_STOP_BIT);

  irq_evt_reg #(.W(DATA_W), .RST(EVT_RST)) u_evt (
    .clk(clk), .rst_n(rst_n), .clr_en(evt_wr), .clr_bits(wr_data),
    .set_bits(set_all), .q(evt_q)
  );

  irq_msk_reg #(.W(DATA_W), .RST(MSK_RST)) u_msk (
    .clk(clk), .rst_n(rst_n), .ld_en(msk_wr), .ld_data(wr_data), .q(msk_q)
  );

  irq_grp_reduce #(.W(DATA_W), .N(NUM_LINES), .GROUPS(GROUPS)) u_grp (
    .evt(evt_q), .msk(msk_q), .lines(lines)
  );

  assign irq_tx  = lines[LINE_TX];
  assign irq_rx  = lines[LINE_RX];
  assign irq_err = lines[LINE_ERR];

  always_comb begin
    if (rd_addr == EVT_ADDR)      rd_data = evt_q;
    else if (rd_addr == MSK_ADDR) rd_data = msk_q;
    else                          rd_data = '0;
  end
endmodule

// File: rtl/irq_event_agg_chk.sv
module irq_event_agg_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter logic [DATA_W-1:0] TX_GROUP  = '0,
  parameter logic [DATA_W-1:0] RX_GROUP  = '0,
  parameter logic [DATA_W-1:0] ERR_GROUP = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] evt_q,
  input logic [DATA_W-1:0] msk_q,
  input logic [DATA_W-1:0] set_all,
  input logic              irq_tx,
  input logic              irq_rx,
  input logic              irq_err
);
  localparam logic [DATA_W-1:0] ANY_GROUP = TX_GROUP | RX_GROUP | ERR_GROUP;

  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(0)) |=> ((evt_q & $past(wr_data & ~set_all)) == '0));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(1)) |=> (msk_q == $past(wr_data)));

  assert_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all != '0) |=> ((evt_q & $past(set_all)) == $past(set_all)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && set_all == '0) |=> ($stable(evt_q) && $stable(msk_q)));

  assert_tx_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx == (|(evt_q & msk_q & TX_GROUP)));

  assert_err_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err == (|(evt_q & msk_q & ERR_GROUP)));

  assert_ungrouped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & msk_q & ANY_GROUP) == '0) |-> !(irq_tx || irq_rx || irq_err));
endmodule

bind irq_event_agg irq_event_agg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .TX_GROUP(TX_GROUP), .RX_GROUP(RX_GROUP), .ERR_GROUP(ERR_GROUP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .evt_q(evt_q), .msk_q(msk_q), .set_all(set_all),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
);

// File: tb/irq_event_agg_bench.sv
module irq_event_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] hw_set = '0;
  logic        rx_stop_done = 1'b0;
  logic        tx_stop_done = 1'b0;
  logic        irq_tx, irq_rx, irq_err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_event_agg u_irq_event_agg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hw_set(hw_set),
    .rx_stop_done(rx_stop_done), .tx_stop_done(tx_stop_done),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] set;
    logic [31:0] x_evt;
    logic [31:0] x_msk;
    logic [2:0]  x_irq;   // {err, rx, tx}
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 32'h0,          32'h0101_0101, 32'h0101_0101, 32'h0,          3'b000}, // R4
    '{1'b1, 2'd1, 32'hFFFF_FFFF,  32'h0,         32'h0101_0101, 32'hFFFF_FFFF,  3'b111}, // R3 R6
    '{1'b1, 2'd0, 32'h0000_0001,  32'h0,         32'h0101_0100, 32'hFFFF_FFFF,  3'b110}, // R2
    '{1'b1, 2'd1, 32'h0000_FF00,  32'h0,         32'h0101_0100, 32'h0000_FF00,  3'b010}, // R3 R6
    '{1'b1, 2'd0, 32'h0000_0100,  32'h0000_0100, 32'h0101_0100, 32'h0000_FF00,  3'b010}, // R5
    '{1'b1, 2'd0, 32'h0101_0100,  32'h0,         32'h0,          32'h0000_FF00,  3'b000}, // R2
    '{1'b1, 2'd1, 32'hFFFF_FFFF,  32'hFF00_0000, 32'hFF00_0000,  32'hFFFF_FFFF,  3'b000}, // R7
    '{1'b1, 2'd2, 32'hFFFF_FFFF,  32'h0,         32'hFF00_0000,  32'hFFFF_FFFF,  3'b000}, // R9
    '{1'b0, 2'd0, 32'h0,          32'h0002_0000, 32'hFF02_0000,  32'hFFFF_FFFF,  3'b100}, // R4 R6
    '{1'b1, 2'd0, 32'hFFFF_FFFF,  32'h0,         32'h0,          32'hFFFF_FFFF,  3'b000}  // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic observe(input string req, input logic [31:0] x_evt,
                         input logic [31:0] x_msk, input logic [2:0] x_irq);
    rd_addr = 2'd0; #0.5;
    check({req, " event"}, rd_data, x_evt);
    rd_addr = 2'd1; #0.5;
    check({req, " mask"}, rd_data, x_msk);
    check({req, " lines"}, {29'd0, irq_err, irq_rx, irq_tx}, {29'd0, x_irq});
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state, lines evaluated from reset values
    repeat (3) @(negedge clk);
    observe("R1 in reset", 32'h0, 32'h0, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    observe("R1 after reset", 32'h0, 32'h0, 3'b000);

    for (int i = 0; i < NV; i++) begin
      wr_en = VECS[i].we; wr_addr = VECS[i].addr;
      wr_data = VECS[i].data; hw_set = VECS[i].set;
      @(posedge clk); #0.5;
      wr_en = 1'b0; hw_set = '0;
      observe($sformatf("vector %0d R2-style table", i), VECS[i].x_evt, VECS[i].x_msk, VECS[i].x_irq);
      @(negedge clk);
    end

    // R9: unmapped address reads as zero
    rd_addr = 2'd2; #0.5;
    check("R9 read addr 2", rd_data, 32'h0);
    rd_addr = 2'd3; #0.5;
    check("R9 read addr 3", rd_data, 32'h0);
    @(negedge clk);

    // R8: graceful-stop completion events
    rx_stop_done = 1'b1; tx_stop_done = 1'b1;
    @(posedge clk); #0.5;
    rx_stop_done = 1'b0; tx_stop_done = 1'b0;
    observe("R8 stop events", 32'h0000_0202, 32'hFFFF_FFFF, 3'b011);
    @(negedge clk);

    // R6: masking the receive group drops only the receive line, same cycle
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h0000_00FF;
    @(posedge clk); #0.5;
    wr_en = 1'b0;
    observe("R6 narrowed mask", 32'h0000_0202, 32'h0000_00FF, 3'b001);
    @(negedge clk);

    // R5: hardware set through stop input collides with clear of same bit
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h0000_0002; tx_stop_done = 1'b1;
    @(posedge clk); #0.5;
    wr_en = 1'b0; tx_stop_done = 1'b0;
    observe("R5 stop vs clear", 32'h0000_0202, 32'h0000_00FF, 3'b001);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule